// File: doc/BRIEF.md
# Intercomputer Output Channel Sender

This block drives the transmitting end of a parallel word link between two computers that reuses an ordinary output channel. A local buffer hands it a word count and then supplies words one at a time. Each word goes out on a 36-bit set of lines. After a programmable settling time, the block raises one of two strobes: `ready_o` for a data word, or `fack_o` for a command word. It then holds the word and the strobe until the far side answers with a rising edge on `resume_i`.

For command transfers the far side's interrupt-enable level, `remote_en_i`, is taken as the request, and the sender waits for it before each word. A forced command skips that wait. Every strobe is guarded by a programmable cycle counter. If no resume edge arrives before the counter expires, the strobe is dropped, a one-cycle timeout interrupt is raised, and the rest of the buffer is abandoned. When the last word has been answered, a one-cycle done pulse is raised.

The controller has five states. `ST_IDLE` goes to `ST_WAIT_EN` on a start of an unforced command run, or to `ST_LOAD` on a start of a data run or forced command run. `ST_WAIT_EN` goes to `ST_LOAD` when the remote enable is high. `ST_LOAD` goes to `ST_SETUP` unconditionally. `ST_SETUP` goes to `ST_STROBE` when the settle count is reached. `ST_STROBE` leaves on a resume edge: back to `ST_WAIT_EN` or `ST_LOAD` if words remain, or to `ST_IDLE` with done after the last word. It also goes to `ST_IDLE` with the timeout interrupt when the guard count expires.

Top module: `xlink_tx`

## Requirements
- R1: After reset, `ready_o`, `fack_o`, `tmo_irq_o`, `done_o`, `busy_o` and `src_take_o` are low and `data_o` is zero.
- R2: For each word, `src_take_o` is high for one cycle and `data_o` takes `src_word_i` at the end of that cycle. `mode_i`=0 selects data. The strobe rises exactly `setup_i`+1 cycles after `data_o` changes, and it is `ready_o` for data.
- R3: While a strobe is high, `data_o` is stable. The strobe falls in the cycle after a resume rising edge is sampled, and `data_o` changes no sooner than one cycle after that.
- R4: A resume edge is only counted while a strobe is high. A resume level that rose earlier, or stays high, is not counted until `resume_i` has returned low.
- R5: With `mode_i`=1 and `force_i`=0 (command), no word is taken while `remote_en_i` is low. This check is made before every word, and the strobe used is `fack_o`.
- R6: With `mode_i`=1 and `force_i`=1, command words are sent without waiting for `remote_en_i`.
- R7: Exactly `len_i` words are sent. `done_o` pulses for one cycle, together with the strobe falling after the last resume, and `busy_o` is then low.
- R8: If no resume edge arrives, the strobe stays high for `timeout_i`+1 cycles and then falls. `tmo_irq_o` pulses for one cycle at that point, `busy_o` goes low, `done_o` stays low, and no further word is taken.
- R9: A start while `busy_o` is high is ignored: the running transfer keeps its mode and count.
- R10: A start with `len_i`=0 is ignored, and `busy_o` stays low.
- R11: `ready_o` and `fack_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a buffered run (sampled in idle) |
| mode_i | input | 1 | 0 data words, 1 command words |
| force_i | input | 1 | Command run ignores the remote enable |
| len_i | input | LEN_W | Number of words in the run |
| setup_i | input | SET_W | Settling cycles minus one before the strobe |
| timeout_i | input | TMO_W | Guard cycles minus one while the strobe is high |
| src_word_i | input | DATA_W | Next word from the local buffer |
| src_take_o | output | 1 | Word on `src_word_i` is consumed this cycle |
| data_o | output | DATA_W | Output data lines |
| ready_o | output | 1 | Data word present |
| fack_o | output | 1 | Command word present |
| resume_i | input | 1 | Far side has sampled the lines |
| remote_en_i | input | 1 | Far side accepts a command |
| tmo_irq_o | output | 1 | One-cycle timeout interrupt |
| done_o | output | 1 | One-cycle run-complete pulse |
| busy_o | output | 1 | Run in progress |

## Verification
The assertions assume three things. `resume_i` and `remote_en_i` are already synchronous to `clk`. The settle and guard limits are captured at start and are not meant to change the running transfer. Only one kind of run is active at a time. The bench changes every input on the falling edge, so the design sees each value for a full cycle. It raises `resume_i` only in response to, or deliberately ahead of, a strobe, and it drops the remote enable together with each resume, as a receiver would. Starts are issued only as single-cycle pulses.

// File: rtl/xlink_pkg.sv
package xlink_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_EN,
        ST_LOAD,
        ST_SETUP,
        ST_STROBE
    } xl_state_e;

    typedef enum logic {
        XM_DATA = 1'b0,
        XM_CMD  = 1'b1
    } xl_mode_e;
endpackage

// File: rtl/xlink_edge.sv
module xlink_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    // Reset value of one: a level already high out of reset is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b1;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/xlink_span.sv
module xlink_span #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr_i)             cnt_q <= '0;
        else if (en_i && !hit_o)    cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = en_i && (cnt_q >= limit_i);

    // Limit is latched at start, so the counter never runs past it.
    assert_span_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |-> (cnt_q <= limit_i));
endmodule

// File: rtl/xlink_fsm.sv
module xlink_fsm
    import xlink_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int LEN_W  = 12,
    parameter int SET_W  = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              force_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [SET_W-1:0]  setup_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic [DATA_W-1:0] src_word_i,
    input  logic              remote_en_i,
    input  logic              resume_rise_i,
    input  logic              setup_hit_i,
    input  logic              tmo_hit_i,
    output logic              setup_clr_o,
    output logic              setup_en_o,
    output logic [SET_W-1:0]  setup_lim_o,
    output logic              tmo_clr_o,
    output logic              tmo_en_o,
    output logic [TMO_W-1:0]  tmo_lim_o,
    output logic              src_take_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              fack_o,
    output logic              tmo_irq_o,
    output logic              done_o,
    output logic              busy_o
);
    xl_state_e         state_q, state_d;
    xl_mode_e          mode_q;
    logic              force_q;
    logic [LEN_W-1:0]  rem_q;
    logic [SET_W-1:0]  setup_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, irq_q;
    logic              go, fin, expire;
    xl_state_e         next_word;

    assign go        = (state_q == ST_IDLE) && start_i && (len_i != '0);
    assign fin       = (state_q == ST_STROBE) && resume_rise_i && (rem_q == LEN_W'(1));
    assign expire    = (state_q == ST_STROBE) && !resume_rise_i && tmo_hit_i;
    assign next_word = (mode_q == XM_CMD && !force_q) ? ST_WAIT_EN : ST_LOAD;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = (mode_i && !force_i) ? ST_WAIT_EN : ST_LOAD;
            end
            ST_WAIT_EN: begin
                if (remote_en_i) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (setup_hit_i) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (resume_rise_i)  state_d = fin ? ST_IDLE : next_word;
                else if (tmo_hit_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Run context, output word and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= XM_DATA;
            force_q <= 1'b0;
            rem_q   <= '0;
            setup_q <= '0;
            tmo_q   <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            done_q <= fin;
            irq_q  <= expire;
            if (go) begin
                mode_q  <= xl_mode_e'(mode_i);
                force_q <= force_i;
                rem_q   <= len_i;
                setup_q <= setup_i;
                tmo_q   <= timeout_i;
            end
            if (state_q == ST_LOAD) data_q <= src_word_i;
            if (state_q == ST_STROBE && resume_rise_i) rem_q <= rem_q - 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        ready_o     = (state_q == ST_STROBE) && (mode_q == XM_DATA);
        fack_o      = (state_q == ST_STROBE) && (mode_q == XM_CMD);
        src_take_o  = (state_q == ST_LOAD);
        busy_o      = (state_q != ST_IDLE);
        setup_clr_o = (state_q == ST_LOAD);
        setup_en_o  = (state_q == ST_SETUP);
        tmo_clr_o   = (state_q != ST_STROBE);
        tmo_en_o    = (state_q == ST_STROBE);
        setup_lim_o = setup_q;
        tmo_lim_o   = tmo_q;
        data_o      = data_q;
        done_o      = done_q;
        tmo_irq_o   = irq_q;
    end

    assert_drop_on_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && resume_rise_i) |=> (!ready_o && !fack_o));

    assert_wait_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_EN && !remote_en_i) |=> (state_q == ST_WAIT_EN));

    assert_forced_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && len_i != '0 && mode_i && force_i) |=> (state_q == ST_LOAD));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(mode_q) && $stable(force_q)));

    assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && len_i == '0) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/xlink_tx.sv
module xlink_tx
    import xlink_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int LEN_W  = 12,
    parameter int SET_W  = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              force_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [SET_W-1:0]  setup_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic [DATA_W-1:0] src_word_i,
    output logic              src_take_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              fack_o,
    input  logic              resume_i,
    input  logic              remote_en_i,
    output logic              tmo_irq_o,
    output logic              done_o,
    output logic              busy_o
);
    logic             resume_rise;
    logic             setup_clr, setup_en, setup_hit;
    logic             tmo_clr, tmo_en, tmo_hit;
    logic [SET_W-1:0] setup_lim;
    logic [TMO_W-1:0] tmo_lim;

    xlink_edge u_resume_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (resume_i),
        .rise_o (resume_rise)
    );

    xlink_span #(.CNT_W(SET_W)) u_setup_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (setup_clr),
        .en_i    (setup_en),
        .limit_i (setup_lim),
        .hit_o   (setup_hit)
    );

    xlink_span #(.CNT_W(TMO_W)) u_guard_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmo_clr),
        .en_i    (tmo_en),
        .limit_i (tmo_lim),
        .hit_o   (tmo_hit)
    );

    xlink_fsm #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .SET_W  (SET_W),
        .TMO_W  (TMO_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .mode_i        (mode_i),
        .force_i       (force_i),
        .len_i         (len_i),
        .setup_i       (setup_i),
        .timeout_i     (timeout_i),
        .src_word_i    (src_word_i),
        .remote_en_i   (remote_en_i),
        .resume_rise_i (resume_rise),
        .setup_hit_i   (setup_hit),
        .tmo_hit_i     (tmo_hit),
        .setup_clr_o   (setup_clr),
        .setup_en_o    (setup_en),
        .setup_lim_o   (setup_lim),
        .tmo_clr_o     (tmo_clr),
        .tmo_en_o      (tmo_en),
        .tmo_lim_o     (tmo_lim),
        .src_take_o    (src_take_o),
        .data_o        (data_o),
        .ready_o       (ready_o),
        .fack_o        (fack_o),
        .tmo_irq_o     (tmo_irq_o),
        .done_o        (done_o),
        .busy_o        (busy_o)
    );

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o || fack_o) |-> $stable(data_o));

    // A resume level that was already high is not a new edge: the strobe stays up unless it times out.
    assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_o || fack_o) && resume_i && $past(resume_i) && $past(ready_o || fack_o))
        |=> ((ready_o || fack_o) || tmo_irq_o));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !tmo_irq_o && !ready_o && !fack_o));

    assert_tmo_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq_o |-> (!busy_o && !ready_o && !fack_o));
endmodule

// File: tb/xlink_tx_bench.sv
module xlink_tx_bench;
    localparam int CLK_P = 10;
    localparam logic [35:0] BASE = 36'h5_A000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, mode_i = 1'b0, force_i = 1'b0;
    logic [11:0] len_i = '0;
    logic [7:0]  setup_i = '0;
    logic [15:0] timeout_i = '0;
    logic [35:0] src_word_i;
    logic        src_take_o;
    logic [35:0] data_o;
    logic        ready_o, fack_o, tmo_irq_o, done_o, busy_o;
    logic        resume_i = 1'b0, remote_en_i = 1'b0;
    int          take_cnt = 0;
    int          total = 0, bad = 0, nxt = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) if (src_take_o) take_cnt <= take_cnt + 1;
    assign src_word_i = BASE + 36'(take_cnt);

    xlink_tx u_xlink_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .force_i(force_i),
        .len_i(len_i), .setup_i(setup_i), .timeout_i(timeout_i), .src_word_i(src_word_i),
        .src_take_o(src_take_o), .data_o(data_o), .ready_o(ready_o), .fack_o(fack_o),
        .resume_i(resume_i), .remote_en_i(remote_en_i), .tmo_irq_o(tmo_irq_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    function automatic logic [35:0] wrd(input int n);
        return BASE + 36'(n);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_start(input bit m, input bit f, input int n, input int st, input int tmo);
        @(negedge clk);
        mode_i = m; force_i = f; len_i = 12'(n); setup_i = 8'(st); timeout_i = 16'(tmo);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Waits for the strobe, checks timing and hold, answers with resume.
    task automatic run_word(input logic [35:0] exp_w, input int st, input bit cmd, input int hold,
                            input bit last, input bit chk_t, input string req);
        int cs = 0;
        int guard = 0;
        logic [35:0] prev = data_o;
        while (!(ready_o || fack_o) && guard < 2000) begin
            @(negedge clk); guard++;
            if (data_o !== prev) begin cs = 0; prev = data_o; end
            else cs++;
        end
        chk(data_o == exp_w, req, "word on lines", data_o, exp_w);
        if (chk_t) chk(cs == st + 1, "R2", "settle cycles before strobe", cs, st + 1);
        chk(ready_o == !cmd && fack_o == cmd, cmd ? "R5" : "R2", "strobe kind",
            {ready_o, fack_o}, cmd ? 1 : 2);
        chk(!(ready_o && fack_o), "R11", "strobes exclusive", {ready_o, fack_o}, cmd ? 1 : 2);
        repeat (hold) begin
            @(negedge clk);
            chk((ready_o || fack_o) && data_o == exp_w, "R3", "held until resume", data_o, exp_w);
        end
        resume_i = 1'b1;
        if (cmd) remote_en_i = 1'b0;
        @(negedge clk);
        chk(!ready_o && !fack_o && data_o == exp_w, "R3", "strobe down before next word",
            {ready_o, fack_o, 1'b0}, 0);
        chk(done_o == last, "R7", "done pulse", done_o, last);
        resume_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!ready_o && !fack_o && !tmo_irq_o && !done_o && !busy_o && !src_take_o, "R1",
            "outputs low in reset", {ready_o, fack_o, tmo_irq_o, done_o, busy_o, src_take_o}, 0);
        chk(data_o == '0, "R1", "lines zero in reset", data_o, 0);
    endtask

    task automatic t_data_run();
        do_start(1'b0, 1'b0, 3, 2, 300);
        for (int k = 0; k < 3; k++) begin
            run_word(wrd(nxt), 2, 1'b0, 2 + k, k == 2, 1'b1, "R2");
            nxt++;
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R7", "single done pulse, idle after run", {done_o, busy_o}, 0);
    endtask

    task automatic t_rearm();
        do_start(1'b0, 1'b0, 1, 3, 300);
        resume_i = 1'b1;
        run_word_hold_high();
    endtask

    task automatic run_word_hold_high();
        int guard = 0;
        while (!ready_o && guard < 200) begin @(negedge clk); guard++; end
        chk(ready_o && data_o == wrd(nxt), "R4", "early resume not counted", data_o, wrd(nxt));
        repeat (4) begin
            @(negedge clk);
            chk(ready_o, "R4", "held-high resume not counted", ready_o, 1);
        end
        resume_i = 1'b0;
        @(negedge clk);
        chk(ready_o, "R4", "falling resume not counted", ready_o, 1);
        resume_i = 1'b1;
        @(negedge clk);
        chk(!ready_o && done_o, "R4", "fresh edge counted", {ready_o, done_o}, 1);
        resume_i = 1'b0;
        nxt++;
    endtask

    task automatic t_cmd_enable();
        remote_en_i = 1'b0;
        do_start(1'b1, 1'b0, 2, 1, 300);
        repeat (8) begin
            @(negedge clk);
            chk(!fack_o && data_o == wrd(nxt - 1), "R5", "no word before enable", data_o, wrd(nxt - 1));
        end
        remote_en_i = 1'b1;
        run_word(wrd(nxt), 1, 1'b1, 1, 1'b0, 1'b1, "R5");
        nxt++;
        repeat (6) begin
            @(negedge clk);
            chk(!fack_o && busy_o, "R5", "second word waits for enable", {fack_o, busy_o}, 1);
        end
        remote_en_i = 1'b1;
        run_word(wrd(nxt), 1, 1'b1, 0, 1'b1, 1'b1, "R5");
        nxt++;
    endtask

    task automatic t_forced();
        remote_en_i = 1'b0;
        do_start(1'b1, 1'b1, 1, 1, 300);
        run_word(wrd(nxt), 1, 1'b1, 3, 1'b1, 1'b1, "R6");
        nxt++;
    endtask

    task automatic t_timeout();
        int hi = 0;
        int guard = 0;
        do_start(1'b0, 1'b0, 3, 2, 4);
        while (!ready_o && guard < 200) begin @(negedge clk); guard++; end
        while (ready_o && hi < 100) begin hi++; @(negedge clk); end
        chk(hi == 5, "R8", "strobe cycles before timeout", hi, 5);
        chk(tmo_irq_o && !busy_o && !done_o, "R8", "interrupt, idle, no done",
            {tmo_irq_o, busy_o, done_o}, 4);
        @(negedge clk);
        chk(!tmo_irq_o, "R8", "interrupt one cycle", tmo_irq_o, 0);
        repeat (4) @(negedge clk);
        chk(data_o == wrd(nxt) && !busy_o && !ready_o, "R8", "remaining words abandoned", data_o, wrd(nxt));
        nxt++;
    endtask

    task automatic t_busy_start();
        do_start(1'b0, 1'b0, 2, 2, 300);
        mode_i = 1'b1; force_i = 1'b1; len_i = 12'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        run_word(wrd(nxt), 2, 1'b0, 1, 1'b0, 1'b0, "R9");
        nxt++;
        run_word(wrd(nxt), 2, 1'b0, 1, 1'b1, 1'b1, "R9");
        nxt++;
        repeat (3) @(negedge clk);
        chk(!busy_o && data_o == wrd(nxt - 1), "R9", "second start had no effect", data_o, wrd(nxt - 1));
    endtask

    task automatic t_zero_len();
        do_start(1'b0, 1'b0, 0, 1, 300);
        repeat (5) begin
            @(negedge clk);
            chk(!busy_o && !ready_o && data_o == wrd(nxt - 1), "R10", "zero-length start ignored",
                {busy_o, ready_o}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_data_run();
        t_rearm();
        t_cmd_enable();
        t_forced();
        t_timeout();
        t_busy_start();
        t_zero_len();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not end act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule